// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Register Space

This block is the configuration register file of a multi-function I/O controller. A host reaches it through two byte-wide addresses. The low address (address bit 0 clear) is the index port and the high address (address bit 0 set) is the data port. After reset the space is locked. The only thing the block listens for while locked is a two-byte unlock key written to the index port. A separate exit key written to the same port locks it again.

While the space is unlocked, the index port selects a register and the data port reads or writes it. Indices below 0x30 address global registers: the logical device selector, identification, power enables, power management and oscillator control. Indices from 0x30 upward address the register bank of the logical device that the selector currently names. Every bank holds an activate bit, a 16-bit base address and a primary interrupt select. A bank can also hold a secondary interrupt select (keyboard only), a DMA channel select (floppy and parallel only) and the floppy mode and option registers (floppy only), depending on its device. The block drives every stored setting onto output signals, where the device functions pick them up.

Host access uses a synchronous strobe. Writes take effect at the clock edge that samples the strobe. Read data is registered and is valid in the cycle after the read strobe.

Top module: `cfg_port_regs`

## Requirements
- R1: After reset the space is locked (`cfg_open` = 0), every exported setting is 0 and `acc_rdata` is 0x00.
- R2: While locked, every read returns 0xFF on either port, and data-port writes change no register and no output.
- R3: Two consecutive writes of 0x55 to the index port unlock the space. Any other byte written to the index port between them restarts the count.
- R4: While unlocked, writing 0xAA to the index port locks the space and leaves the stored index unchanged.
- R5: While unlocked, a write to the index port stores the byte as the index, and a read of the index port returns it. `acc_rdata` carries read data in the cycle after the read strobe and holds its value when there is no read.
- R6: Global index 0x20 reads 0x02 and index 0x21 reads the revision value (default 0x01). Writes to both are ignored.
- R7: Global index 0x07 holds the logical device number (floppy 0, IDE1 1, IDE2 2, parallel 3, serial1 4, serial2 5, RTC 6, keyboard 7, aux I/O 8). Bank writes reach only the named device. A number of 9 or above selects no bank: bank reads return 0x00 and bank writes are ignored.
- R8: Bank index 0x30, bit 0, is the activate bit (1 = on). It drives `dev_active[n]` and reads back as 0x00 or 0x01.
- R9: Bank index 0x60 holds the base-address high byte and 0x61 the low byte. Together they drive `dev_base[16n+15:16n]`.
- R10: Bank index 0x70 is the primary interrupt select and drives `dev_irq[8n+7:8n]`. Bank index 0x72 exists only for device 7, where it drives `kbd_irq2`. For other devices, 0x72 reads 0x00 and ignores writes.
- R11: Bank index 0x74 is a DMA channel select that exists only for device 0 (`fdc_dma`) and device 3 (`par_dma`). For other devices it reads 0x00 and ignores writes.
- R12: Device 0's bank holds a mode register at 0x90 (`fdd_mode`) and an option register at 0x91 (`fdd_opt`). `fdd_burst` is 1 exactly when mode bits 3, 2 and 1 are all set.
- R13: Global index 0x22 stores bits 5:0, where bit n enables device n. These drive `dev_pwr_en`, and bits 7:6 read 0. Indices 0x23 and 0x24 are full 8-bit registers driving `pm_cfg` and `osc_cfg`.
- R14: Unimplemented indices (global or bank) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| cfg_open | output | 1 | Configuration space unlocked |
| dev_active | output | NUM_DEV | Activate bit per device |
| dev_base | output | 16*NUM_DEV | Base address per device |
| dev_irq | output | 8*NUM_DEV | Primary interrupt select per device |
| kbd_irq2 | output | 8 | Secondary interrupt select of the keyboard device |
| fdc_dma | output | 8 | DMA select of the floppy device |
| par_dma | output | 8 | DMA select of the parallel device |
| fdd_mode | output | 8 | Floppy mode register |
| fdd_opt | output | 8 | Floppy option register |
| fdd_burst | output | 1 | Floppy burst mode enabled |
| dev_pwr_en | output | PWR_BITS | Power enable per device 0..PWR_BITS-1 |
| pm_cfg | output | 8 | Power management register |
| osc_cfg | output | 8 | Oscillator register |

## Verification
The bench builds the block with its default parameters: nine devices, the keyboard at slot 7, the floppy at slot 0, the parallel port at slot 3 and six power bits. With these values it can reach every bank variant: a bank with a secondary interrupt, a bank with DMA only, a bank with DMA plus the floppy mode registers, and plain banks. It can also write a device number just past the last bank. It drives broken and complete unlock sequences and the exit key, and shows through the outputs that accesses while locked have no effect. The expected read bytes go into a queue, and a monitor compares them one cycle after each read strobe.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam logic [7:0] IX_LDN     = 8'h07;
   localparam logic [7:0] IX_ID      = 8'h20;
   localparam logic [7:0] IX_REV     = 8'h21;
   localparam logic [7:0] IX_PWR     = 8'h22;
   localparam logic [7:0] IX_PM      = 8'h23;
   localparam logic [7:0] IX_OSC     = 8'h24;
   localparam logic [7:0] IX_BANK_LO = 8'h30;
   localparam logic [7:0] IX_ACT     = 8'h30;
   localparam logic [7:0] IX_BASE_HI = 8'h60;
   localparam logic [7:0] IX_BASE_LO = 8'h61;
   localparam logic [7:0] IX_IRQ_A   = 8'h70;
   localparam logic [7:0] IX_IRQ_B   = 8'h72;
   localparam logic [7:0] IX_DMA     = 8'h74;
   localparam logic [7:0] IX_FMODE   = 8'h90;
   localparam logic [7:0] IX_FOPT    = 8'h91;

   typedef struct packed {
      logic        act;
      logic [15:0] base;
      logic [7:0]  irq_a;
      logic [7:0]  irq_b;
      logic [7:0]  dma;
      logic [7:0]  fmode;
      logic [7:0]  fopt;
   } bank_cfg_t;

endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock #(
   parameter logic [7:0] KEY_OPEN  = 8'h55,
   parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open
);

   logic armed;

   initial begin
      if (KEY_OPEN == KEY_CLOSE) $error("open and close keys must differ");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open  <= 1'b0;
         armed <= 1'b0;
      end else if (idx_wr) begin
         if (open) begin
            armed <= 1'b0;
            if (wdata == KEY_CLOSE) open <= 1'b0;
         end else if (wdata == KEY_OPEN) begin
            if (armed) begin
               open  <= 1'b1;
               armed <= 1'b0;
            end else begin
               armed <= 1'b1;
            end
         end else begin
            armed <= 1'b0;
         end
      end
   end

   // R3
   open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(idx_wr && wdata == KEY_OPEN));

   // R3
   broken_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !open && wdata != KEY_OPEN) |=> !open);

   // R4
   close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && open && wdata == KEY_CLOSE) |=> !open);

endmodule

// File: rtl/cfgp_global.sv
module cfgp_global
   import cfgp_pkg::*;
#(
   parameter logic [7:0] ID_VALUE  = 8'h02,
   parameter logic [7:0] REV_VALUE = 8'h01,
   parameter int         PWR_BITS  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [7:0]          idx,
   input  logic [7:0]          wdata,
   output logic [7:0]          ldn,
   output logic [PWR_BITS-1:0] pwr_en,
   output logic [7:0]          pm,
   output logic [7:0]          osc,
   output logic [7:0]          rd_val
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldn    <= '0;
         pwr_en <= '0;
         pm     <= '0;
         osc    <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_LDN:  ldn    <= wdata;
            IX_PWR:  pwr_en <= wdata[PWR_BITS-1:0];
            IX_PM:   pm     <= wdata;
            IX_OSC:  osc    <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         IX_LDN:  rd_val = ldn;
         IX_ID:   rd_val = ID_VALUE;
         IX_REV:  rd_val = REV_VALUE;
         IX_PWR:  rd_val = 8'(pwr_en);
         IX_PM:   rd_val = pm;
         IX_OSC:  rd_val = osc;
         default: rd_val = 8'h00;
      endcase
   end

   // R7
   ldn_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IX_LDN) |=> ldn == $past(wdata));

   // R13
   pwr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IX_PWR) |=> pwr_en == $past(wdata[PWR_BITS-1:0]));

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
   import cfgp_pkg::*;
#(
   parameter bit HAS_IRQ_B = 1'b0,
   parameter bit HAS_DMA   = 1'b0,
   parameter bit HAS_FDD   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] idx,
   input  logic [7:0] wdata,
   output bank_cfg_t  cfg,
   output logic [7:0] rd_val
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.act   <= 1'b0;
         cfg.base  <= '0;
         cfg.irq_a <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_ACT:     cfg.act        <= wdata[0];
            IX_BASE_HI: cfg.base[15:8] <= wdata;
            IX_BASE_LO: cfg.base[7:0]  <= wdata;
            IX_IRQ_A:   cfg.irq_a      <= wdata;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_IRQ_B) begin : g_irq_b
         always_ff @(posedge clk) begin
            if (!rst_n)                         cfg.irq_b <= '0;
            else if (wr_en && idx == IX_IRQ_B)  cfg.irq_b <= wdata;
         end
      end else begin : g_no_irq_b
         assign cfg.irq_b = '0;
      end

      if (HAS_DMA) begin : g_dma
         always_ff @(posedge clk) begin
            if (!rst_n)                      cfg.dma <= '0;
            else if (wr_en && idx == IX_DMA) cfg.dma <= wdata;
         end
      end else begin : g_no_dma
         assign cfg.dma = '0;
      end

      if (HAS_FDD) begin : g_fdd
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cfg.fmode <= '0;
               cfg.fopt  <= '0;
            end else if (wr_en) begin
               if (idx == IX_FMODE) cfg.fmode <= wdata;
               if (idx == IX_FOPT)  cfg.fopt  <= wdata;
            end
         end
      end else begin : g_no_fdd
         assign cfg.fmode = '0;
         assign cfg.fopt  = '0;
      end
   endgenerate

   always_comb begin
      case (idx)
         IX_ACT:     rd_val = {7'b0, cfg.act};
         IX_BASE_HI: rd_val = cfg.base[15:8];
         IX_BASE_LO: rd_val = cfg.base[7:0];
         IX_IRQ_A:   rd_val = cfg.irq_a;
         IX_IRQ_B:   rd_val = cfg.irq_b;
         IX_DMA:     rd_val = cfg.dma;
         IX_FMODE:   rd_val = cfg.fmode;
         IX_FOPT:    rd_val = cfg.fopt;
         default:    rd_val = 8'h00;
      endcase
   end

   // R8
   act_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IX_ACT) |=> cfg.act == $past(wdata[0]));

   // R9
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg.base));

endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
   import cfgp_pkg::*;
#(
   parameter int         NUM_DEV   = 9,
   parameter int         PWR_BITS  = 6,
   parameter int         FDC_DEV   = 0,
   parameter int         PAR_DEV   = 3,
   parameter int         KBD_DEV   = 7,
   parameter logic [7:0] ID_VALUE  = 8'h02,
   parameter logic [7:0] REV_VALUE = 8'h01,
   parameter logic [7:0] KEY_OPEN  = 8'h55,
   parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_stb,
   input  logic                    acc_we,
   input  logic                    acc_addr,
   input  logic [7:0]              acc_wdata,
   output logic [7:0]              acc_rdata,
   output logic                    cfg_open,
   output logic [NUM_DEV-1:0]      dev_active,
   output logic [16*NUM_DEV-1:0]   dev_base,
   output logic [8*NUM_DEV-1:0]    dev_irq,
   output logic [7:0]              kbd_irq2,
   output logic [7:0]              fdc_dma,
   output logic [7:0]              par_dma,
   output logic [7:0]              fdd_mode,
   output logic [7:0]              fdd_opt,
   output logic                    fdd_burst,
   output logic [PWR_BITS-1:0]     dev_pwr_en,
   output logic [7:0]              pm_cfg,
   output logic [7:0]              osc_cfg
);

   localparam logic [7:0] RD_LOCKED = 8'hFF;

   generate
      if (NUM_DEV < 1 || NUM_DEV > 16) begin : g_bad_ndev
         $error("NUM_DEV must be 1..16");
      end
      if (PWR_BITS < 1 || PWR_BITS > 8 || PWR_BITS > NUM_DEV) begin : g_bad_pwr
         $error("PWR_BITS must be 1..8 and not exceed NUM_DEV");
      end
      if (FDC_DEV >= NUM_DEV || PAR_DEV >= NUM_DEV || KBD_DEV >= NUM_DEV) begin : g_bad_slot
         $error("device slots must lie below NUM_DEV");
      end
   endgenerate

   logic              idx_wr, dat_wr, rd_req, in_bank;
   logic [7:0]        index_q;
   logic [7:0]        ldn;
   logic [7:0]        glob_rd;
   logic [7:0]        bank_rd_any;
   logic [NUM_DEV-1:0] bank_wr;
   logic [7:0]        bank_rd [NUM_DEV];
   bank_cfg_t         bank_cfg [NUM_DEV];

   assign idx_wr  = acc_stb && acc_we && !acc_addr;
   assign dat_wr  = acc_stb && acc_we && acc_addr && cfg_open;
   assign rd_req  = acc_stb && !acc_we;
   assign in_bank = (index_q >= IX_BANK_LO);

   cfgp_unlock #(
      .KEY_OPEN  (KEY_OPEN),
      .KEY_CLOSE (KEY_CLOSE)
   ) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_wr (idx_wr),
      .wdata  (acc_wdata),
      .open   (cfg_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         index_q <= '0;
      else if (idx_wr && cfg_open && acc_wdata != KEY_CLOSE)
         index_q <= acc_wdata;
   end

   cfgp_global #(
      .ID_VALUE  (ID_VALUE),
      .REV_VALUE (REV_VALUE),
      .PWR_BITS  (PWR_BITS)
   ) u_global (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (dat_wr && !in_bank),
      .idx    (index_q),
      .wdata  (acc_wdata),
      .ldn    (ldn),
      .pwr_en (dev_pwr_en),
      .pm     (pm_cfg),
      .osc    (osc_cfg),
      .rd_val (glob_rd)
   );

   generate
      for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
         logic [7:0] rd_raw;
         logic       sel;
         assign sel        = (ldn == 8'(g));
         assign bank_wr[g] = dat_wr && in_bank && sel;
         cfgp_bank #(
            .HAS_IRQ_B (g == KBD_DEV),
            .HAS_DMA   (g == FDC_DEV || g == PAR_DEV),
            .HAS_FDD   (g == FDC_DEV)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_wr[g]),
            .idx    (index_q),
            .wdata  (acc_wdata),
            .cfg    (bank_cfg[g]),
            .rd_val (rd_raw)
         );
         assign bank_rd[g]           = sel ? rd_raw : 8'h00;
         assign dev_active[g]        = bank_cfg[g].act;
         assign dev_base[16*g +: 16] = bank_cfg[g].base;
         assign dev_irq[8*g +: 8]    = bank_cfg[g].irq_a;
      end
   endgenerate

   always_comb begin
      bank_rd_any = 8'h00;
      for (int k = 0; k < NUM_DEV; k++) bank_rd_any = bank_rd_any | bank_rd[k];
   end

   assign kbd_irq2  = bank_cfg[KBD_DEV].irq_b;
   assign fdc_dma   = bank_cfg[FDC_DEV].dma;
   assign par_dma   = bank_cfg[PAR_DEV].dma;
   assign fdd_mode  = bank_cfg[FDC_DEV].fmode;
   assign fdd_opt   = bank_cfg[FDC_DEV].fopt;
   assign fdd_burst = &bank_cfg[FDC_DEV].fmode[3:1];

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_rdata <= 8'h00;
      else if (rd_req) begin
         if (!cfg_open)      acc_rdata <= RD_LOCKED;
         else if (!acc_addr) acc_rdata <= index_q;
         else if (in_bank)   acc_rdata <= bank_rd_any;
         else                acc_rdata <= glob_rd;
      end
   end

   // R2
   locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !cfg_open) |=> acc_rdata == RD_LOCKED);

   // R2
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && acc_we && acc_addr && !cfg_open) |=>
         ($stable(dev_active) && $stable(dev_pwr_en) && $stable(dev_base)));

   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(acc_rdata));

   // R7
   one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_wr));

endmodule

// File: tb/cfg_port_regs_test.sv
module cfg_port_regs_test;

   localparam int NDEV = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 1'b0, we = 1'b0, addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       cfg_open;
   logic [NDEV-1:0]    dev_active;
   logic [16*NDEV-1:0] dev_base;
   logic [8*NDEV-1:0]  dev_irq;
   logic [7:0] kbd_irq2, fdc_dma, par_dma, fdd_mode, fdd_opt, pm_cfg, osc_cfg;
   logic       fdd_burst;
   logic [5:0] dev_pwr_en;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       rd_pend = 1'b0;

   always #5 clk = ~clk;

   cfg_port_regs uut (
      .clk(clk), .rst_n(rst_n), .acc_stb(stb), .acc_we(we), .acc_addr(addr),
      .acc_wdata(wdata), .acc_rdata(rdata), .cfg_open(cfg_open),
      .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
      .kbd_irq2(kbd_irq2), .fdc_dma(fdc_dma), .par_dma(par_dma),
      .fdd_mode(fdd_mode), .fdd_opt(fdd_opt), .fdd_burst(fdd_burst),
      .dev_pwr_en(dev_pwr_en), .pm_cfg(pm_cfg), .osc_cfg(osc_cfg)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      stb = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      stb = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      stb = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
      wr(1'b0, ix);
      wr(1'b1, d);
   endtask

   task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
      wr(1'b0, ix);
      rd(1'b1, exp, tag);
   endtask

   // scoreboard monitor
   always @(posedge clk) rd_pend <= stb && !we;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R5: unexpected read result 0x%0h expected none", rdata);
         end else begin
            chk(32'(rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(32'(cfg_open), 0, "R1 cfg_open");
      chk(32'(dev_active), 0, "R1 dev_active");
      chk(32'(dev_pwr_en), 0, "R1 dev_pwr_en");
      chk(32'(rdata), 0, "R1 rdata");
      chk(32'(dev_base[4*16 +: 16]), 0, "R1 dev_base");

      // R2: locked reads and writes
      rd(1'b1, 8'hFF, "R2 locked data read");
      rd(1'b0, 8'hFF, "R2 locked index read");
      wr(1'b1, 8'h3F);
      chk(32'(dev_pwr_en), 0, "R2 locked write pwr");
      chk(32'(dev_active), 0, "R2 locked write act");

      // R3: broken key then complete key
      wr(1'b0, 8'h55);
      wr(1'b0, 8'h10);
      wr(1'b0, 8'h55);
      chk(32'(cfg_open), 0, "R3 broken key stays locked");
      wr(1'b0, 8'h55);
      chk(32'(cfg_open), 1, "R3 unlocked");

      // R5 index readback
      wr(1'b0, 8'h21);
      rd(1'b0, 8'h21, "R5 index readback");

      // R6 identification
      reg_rd(8'h20, 8'h02, "R6 device id");
      reg_rd(8'h21, 8'h01, "R6 revision");
      reg_wr(8'h20, 8'h99);
      reg_rd(8'h20, 8'h02, "R6 id read-only");

      // R8 R9 R10 on serial1 (device 4)
      reg_wr(8'h07, 8'h04);
      reg_rd(8'h07, 8'h04, "R7 ldn readback");
      reg_wr(8'h60, 8'h03);
      reg_wr(8'h61, 8'hF8);
      reg_wr(8'h70, 8'h04);
      reg_wr(8'h30, 8'h01);
      chk(32'(dev_base[4*16 +: 16]), 32'h03F8, "R9 base dev4");
      chk(32'(dev_irq[4*8 +: 8]), 32'h04, "R10 irq dev4");
      chk(32'(dev_active), 32'h010, "R8 active dev4");
      reg_rd(8'h60, 8'h03, "R9 base hi read");
      reg_rd(8'h30, 8'h01, "R8 activate read");

      // R7 other bank independent
      reg_wr(8'h07, 8'h05);
      reg_wr(8'h60, 8'h02);
      reg_wr(8'h61, 8'hF8);
      chk(32'(dev_base[5*16 +: 16]), 32'h02F8, "R7 base dev5");
      chk(32'(dev_base[4*16 +: 16]), 32'h03F8, "R7 dev4 untouched");
      reg_rd(8'h30, 8'h00, "R7 dev5 activate independent");

      // R10 secondary irq only for keyboard
      reg_wr(8'h72, 8'h0C);
      reg_rd(8'h72, 8'h00, "R10 irq2 absent dev5");
      chk(32'(kbd_irq2), 0, "R10 kbd_irq2 untouched");
      reg_wr(8'h07, 8'h07);
      reg_wr(8'h72, 8'h0C);
      chk(32'(kbd_irq2), 32'h0C, "R10 kbd_irq2");
      reg_rd(8'h72, 8'h0C, "R10 irq2 read");

      // R11 DMA select
      reg_wr(8'h07, 8'h00);
      reg_wr(8'h74, 8'h02);
      chk(32'(fdc_dma), 32'h02, "R11 fdc dma");
      reg_wr(8'h07, 8'h03);
      reg_wr(8'h74, 8'h03);
      chk(32'(par_dma), 32'h03, "R11 par dma");
      chk(32'(fdc_dma), 32'h02, "R11 fdc dma kept");
      reg_wr(8'h07, 8'h04);
      reg_wr(8'h74, 8'h01);
      reg_rd(8'h74, 8'h00, "R11 dma absent dev4");

      // R12 floppy mode / option
      reg_wr(8'h07, 8'h00);
      reg_wr(8'h90, 8'h06);
      chk(32'(fdd_burst), 0, "R12 burst partial bits");
      reg_wr(8'h90, 8'h0E);
      chk(32'(fdd_burst), 1, "R12 burst on");
      chk(32'(fdd_mode), 32'h0E, "R12 mode");
      reg_wr(8'h91, 8'h5A);
      reg_rd(8'h91, 8'h5A, "R12 option read");
      chk(32'(fdd_opt), 32'h5A, "R12 option");

      // R7 out-of-range device number
      reg_wr(8'h07, 8'h09);
      reg_wr(8'h30, 8'h01);
      chk(32'(dev_active), 32'h010, "R7 ldn 9 write ignored");
      reg_rd(8'h60, 8'h00, "R7 ldn 9 read zero");

      // R13 power, pm, osc
      reg_wr(8'h22, 8'hFF);
      chk(32'(dev_pwr_en), 32'h3F, "R13 pwr enables");
      reg_rd(8'h22, 8'h3F, "R13 pwr upper bits zero");
      reg_wr(8'h23, 8'hA5);
      reg_wr(8'h24, 8'h05);
      chk(32'(pm_cfg), 32'hA5, "R13 pm");
      chk(32'(osc_cfg), 32'h05, "R13 osc");

      // R14 unimplemented indices
      reg_wr(8'h2F, 8'h77);
      reg_rd(8'h2F, 8'h00, "R14 global gap");
      reg_wr(8'h07, 8'h04);
      reg_wr(8'h40, 8'h77);
      reg_rd(8'h40, 8'h00, "R14 bank gap");
      reg_rd(8'h61, 8'hF8, "R14 neighbour kept");

      // R4 lock with exit key, index preserved
      wr(1'b0, 8'h22);
      wr(1'b0, 8'hAA);
      chk(32'(cfg_open), 0, "R4 locked");
      rd(1'b1, 8'hFF, "R4 locked read");
      wr(1'b1, 8'h00);
      chk(32'(dev_pwr_en), 32'h3F, "R2 write after lock ignored");
      wr(1'b0, 8'h55);
      wr(1'b0, 8'h55);
      rd(1'b0, 8'h22, "R4 index preserved");
      rd(1'b1, 8'h3F, "R4 pwr after reopen");

      repeat (3) @(negedge clk);
      chk(32'(exp_q.size()), 0, "R5 all reads returned");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule